// File: doc/BRIEF.md
# Systolic Approximate String Distance Array

This block finds where a short pattern occurs approximately inside a stored text. A linear row of cells holds one text character each. After a start pulse, pattern characters enter the leftmost cell one per step and travel right by one cell per step. Every cell computes one entry of the edit-distance matrix for the pattern row that is passing through it. The distance for a text position is the smallest number of inserted, deleted or changed characters that makes the pattern match a stretch of text ending at that position.

The result for text position j is final once the last pattern character has been processed in cell j. The block then reports it on a single result port with its position and a one-cycle valid strobe. Results arrive in increasing position order, one per step. The host loads the text with indexed writes. It then issues a start pulse carrying the pattern and text lengths, and drives pattern length plus text length steps, giving one pattern character on each of the first pattern-length steps.

Top module: `sdist_array`

## Requirements
- R1: After reset dist_valid is low, and steps issued before the first start pulse produce no result.
- R2: A cycle with text_we high writes text_char into the cell at text_idx. A later write to one position replaces only that character, and the following distances are computed against the updated text.
- R3: A start pulse latches pat_len and txt_len and clears the working state of every cell. A step in the same cycle as start is ignored. dist_valid is low in the cycle after start.
- R4: Counting the first step after start as step 0, the first pat_len steps take pat_char as pattern characters 0 to pat_len-1. The pat_char value on any later step has no effect on the results.
- R5: Matrix entry (i, j) equals the minimum of entry (i, j-1), entry (i-1, j) and entry (i-1, j-1), plus 1 when pattern character i differs from text character j. The comparison is an 8-bit equality test, and scores are 8-bit unsigned.
- R6: For pattern row 0 the upward and diagonal inputs are 0. At text position 0 the backward input is 255, and the diagonal input is 255 for every row after row 0.
- R7: Step k produces dist_valid high in the next cycle when e = k - pat_len lies in 0 to txt_len-1. In that cycle dist_idx = e and dist_val is the last-row entry for position e. Otherwise dist_valid is low. At most one result appears per cycle, and consecutive results have consecutive indices.
- R8: Positions at or beyond txt_len are never reported, even when more characters are loaded.
- R9: A reported distance is 0 exactly where the whole pattern occurs in the text ending at that position.
- R10: Text AAATCGATTGAA with pattern ATCG yields the distances 3 3 3 2 1 0 1 2 2 1 2 3 for positions 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| text_we | input | 1 | Write strobe for one text character |
| text_idx | input | IDX_W (4) | Text position written by text_we |
| text_char | input | CHAR_W (8) | Text character to write |
| start | input | 1 | Begin a new search; latches the lengths and clears the array |
| pat_len | input | PLEN_W (5) | Pattern length, sampled on start, 1 or more |
| txt_len | input | TLEN_W (5) | Number of text positions to report, sampled on start |
| step | input | 1 | Advance the array by one systolic step |
| pat_char | input | CHAR_W (8) | Pattern character for this step |
| dist_valid | output | 1 | One-cycle strobe marking a final distance |
| dist_idx | output | IDX_W (4) | Text position of the reported distance |
| dist_val | output | SCORE_W (8) | Reported distance |

## Verification
The assertions rely on the host never raising step and start together unless start is meant to win. They also require txt_len to be no larger than the number of cells, and the pattern to be fed only after a start. If txt_len were larger, the index range and one-result-per-cycle properties would lose their meaning. The stimulus loads the text before each start and keeps txt_len within 1 to 16. It drives exactly one character per step through tasks. The one deliberate overlap of start and step is the case that checks the start priority.

// File: rtl/sdist_pkg.sv
package sdist_pkg;

    // Marker bits that travel with every pattern character through the array.
    typedef struct packed {
        logic live;   // slot carries a real pattern character
        logic first;  // character is pattern row 0
        logic last;   // character is the final pattern row
    } ptag_t;

endpackage

// File: rtl/sdist_feed.sv
module sdist_feed #(
    parameter int PLEN_W = 5,
    parameter int TLEN_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    input  logic [PLEN_W-1:0]       plen_in,
    input  logic [TLEN_W-1:0]       tlen_in,
    output sdist_pkg::ptag_t        head_tag,
    output logic [TLEN_W-1:0]       tlen_q
);
    typedef struct packed {
        logic [PLEN_W-1:0] cnt;
        logic [PLEN_W-1:0] plen;
        logic [TLEN_W-1:0] tlen;
    } feed_t;

    feed_t st_d, st_q;
    logic  live;

    always_comb begin
        st_d = st_q;
        live = (st_q.cnt < st_q.plen);
        if (clr) begin
            st_d.cnt  = '0;
            st_d.plen = plen_in;
            st_d.tlen = tlen_in;
        end else if (adv && live) begin
            st_d.cnt = st_q.cnt + PLEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_tag.live  = live;
    assign head_tag.first = (st_q.cnt == '0);
    assign head_tag.last  = (st_q.cnt == st_q.plen - PLEN_W'(1));
    assign tlen_q         = st_q.tlen;

endmodule

// File: rtl/sdist_shift.sv
module sdist_shift #(
    parameter int N_CELLS = 16,
    parameter int CHAR_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                adv,
    input  logic [CHAR_W-1:0]                   head_chr,
    input  sdist_pkg::ptag_t                    head_tag,
    output logic [N_CELLS-1:0][CHAR_W-1:0]      cur_chr,
    output sdist_pkg::ptag_t [N_CELLS-1:0]      cur_tag
);
    typedef struct packed {
        logic [CHAR_W-1:0] c;
        sdist_pkg::ptag_t  g;
    } slot_t;

    slot_t [N_CELLS-1:0] sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (clr) begin
            sl_d = '0;
        end else if (adv) begin
            sl_d[0].c = head_chr;
            sl_d[0].g = head_tag;
            for (int j = 1; j < N_CELLS; j++) begin
                sl_d[j] = sl_q[j-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    for (genvar j = 0; j < N_CELLS; j++) begin : g_out
        assign cur_chr[j] = sl_q[j].c;
        assign cur_tag[j] = sl_q[j].g;
    end

endmodule

// File: rtl/sdist_cell.sv
module sdist_cell #(
    parameter int CHAR_W  = 8,
    parameter int SCORE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    input  logic               text_we,
    input  logic [CHAR_W-1:0]  text_in,
    input  logic [CHAR_W-1:0]  cur_chr,
    input  logic               cur_live,
    input  logic               cur_first,
    input  logic [SCORE_W-1:0] left_r,
    output logic [SCORE_W-1:0] r_q
);
    typedef struct packed {
        logic [CHAR_W-1:0]  t;   // stored text character
        logic [SCORE_W-1:0] b;   // left neighbour result from the previous step
        logic [SCORE_W-1:0] r;   // own result
    } cell_t;

    cell_t st_d, st_q;
    logic [SCORE_W-1:0] up_v, dg_v, m_v;
    logic               miss;

    function automatic logic [SCORE_W-1:0] min3(input logic [SCORE_W-1:0] a,
                                                input logic [SCORE_W-1:0] b,
                                                input logic [SCORE_W-1:0] c);
        logic [SCORE_W-1:0] t;
        t = (a < b) ? a : b;
        return (t < c) ? t : c;
    endfunction

    always_comb begin
        st_d = st_q;
        up_v = cur_first ? '0 : st_q.r;
        dg_v = cur_first ? '0 : st_q.b;
        m_v  = min3(left_r, up_v, dg_v);
        miss = (cur_chr != st_q.t);
        if (text_we) st_d.t = text_in;
        if (clr) begin
            st_d.b = '0;
            st_d.r = '0;
        end else if (adv) begin
            st_d.b = left_r;
            if (cur_live) begin
                if (miss && (m_v == '1)) st_d.r = m_v;
                else                     st_d.r = m_v + SCORE_W'(miss);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign r_q = st_q.r;

endmodule

// File: rtl/sdist_pick.sv
module sdist_pick #(
    parameter int N_CELLS = 16,
    parameter int SCORE_W = 8,
    parameter int IDX_W   = 4,
    parameter int TLEN_W  = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_CELLS-1:0]                fin_vec,
    input  logic [N_CELLS-1:0][SCORE_W-1:0]   r_vec,
    input  logic [TLEN_W-1:0]                 tlen,
    output logic                              dist_valid,
    output logic [IDX_W-1:0]                  dist_idx,
    output logic [SCORE_W-1:0]                dist_val
);
    typedef struct packed {
        logic             v;
        logic [IDX_W-1:0] idx;
    } pick_t;

    pick_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = 1'b0;
        for (int j = 0; j < N_CELLS; j++) begin
            if (fin_vec[j] && (TLEN_W'(j) < tlen)) begin
                st_d.v   = 1'b1;
                st_d.idx = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dist_valid = st_q.v;
    assign dist_idx   = st_q.idx;
    assign dist_val   = r_vec[st_q.idx];

endmodule

// File: rtl/sdist_array.sv
module sdist_array #(
    parameter  int N_CELLS = 16,
    parameter  int CHAR_W  = 8,
    parameter  int SCORE_W = 8,
    parameter  int PLEN_W  = 5,
    localparam int IDX_W   = $clog2(N_CELLS),
    localparam int TLEN_W  = $clog2(N_CELLS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               text_we,
    input  logic [IDX_W-1:0]   text_idx,
    input  logic [CHAR_W-1:0]  text_char,
    input  logic               start,
    input  logic [PLEN_W-1:0]  pat_len,
    input  logic [TLEN_W-1:0]  txt_len,
    input  logic               step,
    input  logic [CHAR_W-1:0]  pat_char,
    output logic               dist_valid,
    output logic [IDX_W-1:0]   dist_idx,
    output logic [SCORE_W-1:0] dist_val
);
    import sdist_pkg::*;

    logic                            adv;
    ptag_t                           head_tag;
    logic [TLEN_W-1:0]               tlen_q;
    logic [N_CELLS-1:0][CHAR_W-1:0]  cur_chr;
    ptag_t [N_CELLS-1:0]             cur_tag;
    logic [N_CELLS-1:0][SCORE_W-1:0] r_vec;
    logic [N_CELLS-1:0]              fin_vec;

    // start has priority: a step in the start cycle is dropped
    assign adv = step & ~start;

    sdist_feed #(.PLEN_W(PLEN_W), .TLEN_W(TLEN_W)) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .adv      (adv),
        .plen_in  (pat_len),
        .tlen_in  (txt_len),
        .head_tag (head_tag),
        .tlen_q   (tlen_q)
    );

    sdist_shift #(.N_CELLS(N_CELLS), .CHAR_W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .adv      (adv),
        .head_chr (pat_char),
        .head_tag (head_tag),
        .cur_chr  (cur_chr),
        .cur_tag  (cur_tag)
    );

    for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
        logic [SCORE_W-1:0] left_r;
        if (j == 0) begin : g_edge
            assign left_r = '1;
        end else begin : g_inner
            assign left_r = r_vec[j-1];
        end

        sdist_cell #(.CHAR_W(CHAR_W), .SCORE_W(SCORE_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (start),
            .adv       (adv),
            .text_we   (text_we && (text_idx == IDX_W'(j))),
            .text_in   (text_char),
            .cur_chr   (cur_chr[j]),
            .cur_live  (cur_tag[j].live),
            .cur_first (cur_tag[j].first),
            .left_r    (left_r),
            .r_q       (r_vec[j])
        );

        assign fin_vec[j] = adv & cur_tag[j].live & cur_tag[j].last;
    end

    sdist_pick #(.N_CELLS(N_CELLS), .SCORE_W(SCORE_W), .IDX_W(IDX_W), .TLEN_W(TLEN_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_vec    (fin_vec),
        .r_vec      (r_vec),
        .tlen       (tlen_q),
        .dist_valid (dist_valid),
        .dist_idx   (dist_idx),
        .dist_val   (dist_val)
    );

endmodule

// File: rtl/sdist_chk.sv
module sdist_chk #(
    parameter int N_CELLS = 16,
    parameter int IDX_W   = 4,
    parameter int TLEN_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               step,
    input logic               dist_valid,
    input logic [IDX_W-1:0]   dist_idx,
    input logic [N_CELLS-1:0] fin_vec,
    input logic [TLEN_W-1:0]  tlen_q
);
    // R7: only one cell may finish its last pattern row per step
    p_one_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fin_vec));

    // R7: a result only follows an accepted step
    p_valid_after_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |-> $past(step && !start));

    // R3: start clears, so nothing is reported in the following cycle
    p_start_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !dist_valid);

    // R8: reported positions stay below the latched text length
    p_idx_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dist_valid |-> (TLEN_W'(dist_idx) < tlen_q));

    // R7: back-to-back results walk the text left to right
    p_idx_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_valid && $past(dist_valid)) |-> (dist_idx - $past(dist_idx) == IDX_W'(1)));

endmodule

bind sdist_array sdist_chk #(.N_CELLS(N_CELLS), .IDX_W(IDX_W), .TLEN_W(TLEN_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (step),
    .dist_valid (dist_valid),
    .dist_idx   (dist_idx),
    .fin_vec    (fin_vec),
    .tlen_q     (tlen_q)
);

// File: tb/test_sdist_array.sv
`timescale 1ns/1ps
module test_sdist_array;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       text_we = 1'b0;
    logic [3:0] text_idx = '0;
    logic [7:0] text_char = '0;
    logic       start = 1'b0;
    logic [4:0] pat_len = '0;
    logic [4:0] txt_len = '0;
    logic       step = 1'b0;
    logic [7:0] pat_char = '0;
    logic       dist_valid;
    logic [3:0] dist_idx;
    logic [7:0] dist_val;

    always #2.5 clk = ~clk;

    sdist_array i_sdist_array (
        .clk(clk), .rst_n(rst_n), .text_we(text_we), .text_idx(text_idx),
        .text_char(text_char), .start(start), .pat_len(pat_len), .txt_len(txt_len),
        .step(step), .pat_char(pat_char), .dist_valid(dist_valid),
        .dist_idx(dist_idx), .dist_val(dist_val)
    );

    typedef struct packed {
        logic [127:0] txt;
        logic [4:0]   tn;   // characters held in txt
        logic [4:0]   tl;   // txt_len given on start
        logic [127:0] pat;
        logic [4:0]   pl;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{txt:"AAATCGATTGAA",     tn:5'd12, tl:5'd12, pat:"ATCG",             pl:5'd4},
        '{txt:"GATTACAGATTACA",   tn:5'd14, tl:5'd14, pat:"TACA",             pl:5'd4},
        '{txt:"CCCCCCCCCCCCCCCC", tn:5'd16, tl:5'd16, pat:"GGG",              pl:5'd3},
        '{txt:"ACGTACGTACGTACGT", tn:5'd16, tl:5'd16, pat:"ACGTTACG",         pl:5'd8},
        '{txt:"HELLOWORLD",       tn:5'd10, tl:5'd5,  pat:"WORD",             pl:5'd4},
        '{txt:"GATTACA",          tn:5'd7,  tl:5'd7,  pat:"T",                pl:5'd1},
        '{txt:"AAAA",             tn:5'd4,  tl:5'd4,  pat:"CCCCCCCCCCCCCCCC", pl:5'd16}
    };
    localparam int EX [12] = '{3, 3, 3, 2, 1, 0, 1, 2, 2, 1, 2, 3};

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;
    int ref_row [16];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] getc(input logic [127:0] s, input int n, input int j);
        return s[(n-1-j)*8 +: 8];
    endfunction

    // reference matrix built from the recurrence (R5) and edges (R6)
    task automatic model(input vec_t v);
        int prev [16];
        int cur  [16];
        for (int j = 0; j < 16; j++) begin prev[j] = 0; cur[j] = 0; end
        for (int i = 0; i < int'(v.pl); i++) begin
            for (int j = 0; j < int'(v.tl); j++) begin
                int back, up, dg, m, c;
                back = (j == 0) ? 255 : cur[j-1];
                up   = (i == 0) ? 0 : prev[j];
                dg   = (i == 0) ? 0 : ((j == 0) ? 255 : prev[j-1]);
                m = back < up ? back : up;
                m = m < dg ? m : dg;
                c = m + ((getc(v.pat, int'(v.pl), i) != getc(v.txt, int'(v.tn), j)) ? 1 : 0);
                cur[j] = (c > 255) ? 255 : c;
            end
            for (int j = 0; j < 16; j++) prev[j] = cur[j];
        end
        for (int j = 0; j < 16; j++) ref_row[j] = prev[j];
    endtask

    task automatic load_text(input vec_t v);
        for (int j = 0; j < int'(v.tn); j++) begin
            text_we = 1'b1; text_idx = 4'(j); text_char = getc(v.txt, int'(v.tn), j);
            @(negedge clk);
        end
        text_we = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit do_load, input bit dual, input bit is_ex);
        if (do_load) load_text(v);
        model(v);
        if (dual) begin step = 1'b1; pat_char = "Q"; end
        start = 1'b1; pat_len = v.pl; txt_len = v.tl;
        @(negedge clk);
        start = 1'b0; step = 1'b0;
        check(dist_valid == 1'b0, "R3 no result after start", int'(dist_valid), 0);
        for (int k = 0; k < int'(v.pl) + int'(v.tl) + 2; k++) begin
            int e;
            bit exp_v;
            step = 1'b1;
            pat_char = (k < int'(v.pl)) ? getc(v.pat, int'(v.pl), k) : 8'(8'h5A + k); // R4 bubbles
            @(negedge clk);
            step = 1'b0;
            e = k - int'(v.pl);
            exp_v = (e >= 0) && (e < int'(v.tl));
            if (exp_v) begin
                check(dist_valid == 1'b1, "R7 valid strobe", int'(dist_valid), 1);
                check(int'(dist_idx) == e, "R7 position", int'(dist_idx), e);
                check(int'(dist_val) == ref_row[e], "R5 distance", int'(dist_val), ref_row[e]);
                if (ref_row[e] == 0)
                    check(dist_val == 8'd0, "R9 exact match", int'(dist_val), 0);
                if (is_ex)
                    check(int'(dist_val) == EX[e], "R10 example row", int'(dist_val), EX[e]);
            end else begin
                check(dist_valid == 1'b0, (e >= int'(v.tl)) ? "R8 no report past length" : "R7 quiet step",
                      int'(dist_valid), 0);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R7: actual %0d cycles expected below %0d", cyc, 50000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dist_valid == 1'b0, "R1 reset state", int'(dist_valid), 0);
        for (int k = 0; k < 4; k++) begin
            step = 1'b1; pat_char = "A";
            @(negedge clk);
            step = 1'b0;
            check(dist_valid == 1'b0, "R1 step before start", int'(dist_valid), 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b1, 1'b0, i == 0);
        end

        // R3: a step in the start cycle is dropped
        run_vec(VECS[1], 1'b1, 1'b1, 1'b0);

        // R2: single rewrite of position 5 (G -> T)
        load_text(VECS[0]);
        text_we = 1'b1; text_idx = 4'd5; text_char = "T";
        @(negedge clk);
        text_we = 1'b0;
        v = VECS[0];
        v.txt = "AAATCTATTGAA";
        v.pat = "ATCT";
        model(v);
        check(ref_row[5] == 0, "R2 model sanity", ref_row[5], 0);
        run_vec(v, 1'b0, 1'b0, 1'b0);

        // R6: single-character pattern exercises row 0 and position 0 edges
        v = VECS[5];
        v.txt = "TATTACA";
        run_vec(v, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule